// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Break and Preamble Sequences

This block turns bytes offered on a ready/valid interface into asynchronous serial frames on one line that idles high. Each frame is a low start bit, five to eight data bits sent least-significant first, an optional even or odd parity bit and one or two high stop bits. Every line bit lasts exactly one period of an external one-cycle `bitTick` strobe, so the rate is set by whatever divider produces that strobe.

Besides data, the block can drive two special sequences whose length is one frame time of the current format. A break holds the line low for a programmable number of frame times and is always followed by one frame time of high idle. A preamble holds the line high for one frame time in front of a byte that is offered with its preamble flag set. A restart command cuts a running break short. Bytes offered back-to-back without a preamble leave the line with no idle gap between frames.

Top module: `uart_tx_brk`

## Requirements
- R1: While reset is held, `txLine` is 1, `busy` is 0 and `inReady` is 0 when `bitTick` is low.
- R2: A frame starts with one 0 bit, then the data bits least-significant first, where the number of data bits is 5 plus `cfgDataSel` (0 gives 5, 3 gives 8); each bit lasts from one `bitTick` to the next, and the line does not change on cycles without `bitTick`.
- R3: When `cfgParEn` is 1 a parity bit follows the last data bit; with `cfgParOdd` 0 the number of ones across data and parity is even, with `cfgParOdd` 1 it is odd.
- R4: The frame ends with one high stop bit, or two when `cfgTwoStop` is 1.
- R5: `inReady` is high only in a `bitTick` cycle in which the line is idle, or in which the last stop bit of a frame or of a post-break idle ends, and no break is pending; an accepted byte without preamble starts its start bit on that tick, so consecutive frames have no gap.
- R6: A byte accepted with `inPre` 1 is preceded by one frame time of ones (10 bits for 8 data bits, no parity, 1 stop bit).
- R7: A `brkReq` pulse makes the line go low for `brkCount` frame times at the next decision point; a count of 0 sends one frame time; `brkReq` while a break is running is ignored.
- R8: Every break, whether it ran to its count or was cut short, is followed by one frame time of ones before any data, preamble or new break.
- R9: A `restart` pulse during a break makes the line go high on the next `bitTick` and begins the post-break idle; a `restart` outside a break has no effect.
- R10: `busy` is 1 while a break, post-break idle, preamble or data bit is on the line and 0 when the line is idle, and the line is 1 whenever `busy` is 0.
- R11: The format inputs are sampled only when the transmitter leaves idle; a change while it is busy does not alter frames or sequence lengths until it returns to idle.
- R12: At a decision point a pending break is served before a waiting byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitTick | input | 1 | One-cycle strobe marking each bit boundary |
| cfgDataSel | input | 2 | Data bit count minus 5 |
| cfgParEn | input | 1 | Parity bit enable |
| cfgParOdd | input | 1 | 1 selects odd parity, 0 even |
| cfgTwoStop | input | 1 | 1 selects two stop bits |
| brkReq | input | 1 | Pulse requesting a break sequence |
| brkCount | input | BRK_W | Break length in frame times, sampled when the break starts |
| restart | input | 1 | Pulse ending a running break early |
| inValid | input | 1 | Byte offered |
| inData | input | 8 | Byte to send |
| inPre | input | 1 | Send a preamble before this byte |
| inReady | output | 1 | Byte taken on this cycle when `inValid` is high |
| txLine | output | 1 | Serial output, idles high |
| busy | output | 1 | Transmitter active |

## Verification
The bench builds the block with its default `BRK_W` of 8 and a bit strobe every third clock, which keeps every frame format from 7 to 12 bit times inside a short run while leaving room for requests to land between strobes. Break counts of 0, 2 and 5 reach the zero-as-one rule, multi-frame breaks and a restart that lands inside the third break frame. Formats with 5, 7 and 8 data bits, both parity senses and two stop bits bring every frame length and parity position into the reference comparison.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam int MAX_DATA = 8;
  localparam int MIN_DATA = 5;
  localparam int FRAME_W  = MAX_DATA + 4;
  localparam int LEN_W    = $clog2(FRAME_W + 1);

  typedef struct packed {
    logic [1:0] dataSel;
    logic       parEn;
    logic       parOdd;
    logic       twoStop;
  } txCfg_t;

  typedef struct packed {
    logic useIn;
    logic latchByte;
    logic loadFrame;
    logic shift;
    logic setLevel;
    logic level;
  } dpCtl_t;

  function automatic logic [LEN_W-1:0] frameLen(txCfg_t c);
    return LEN_W'(MIN_DATA + 2) + LEN_W'(c.dataSel) + LEN_W'(c.parEn) + LEN_W'(c.twoStop);
  endfunction
endpackage

// File: rtl/uart_tx_dp.sv
module uart_tx_dp
  import uart_tx_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  dpCtl_t              ctl,
  input  txCfg_t              cfg,
  input  logic [MAX_DATA-1:0] inData,
  output logic                txLine
);
  logic [MAX_DATA-1:0] heldByte, srcByte, maskByte;
  logic [FRAME_W-1:0]  frame, shReg;
  logic [LEN_W-1:0]    dataCnt, parPos;
  logic                parBit;

  assign srcByte = ctl.useIn ? inData : heldByte;
  assign dataCnt = LEN_W'(MIN_DATA) + LEN_W'(cfg.dataSel);
  assign parPos  = dataCnt + 1'b1;

  always_comb begin
    for (int i = 0; i < MAX_DATA; i++)
      maskByte[i] = (LEN_W'(i) < dataCnt) ? srcByte[i] : 1'b0;
    parBit = (^maskByte) ^ cfg.parOdd;
    frame = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < MAX_DATA; i++)
      if (LEN_W'(i) < dataCnt) frame[i+1] = maskByte[i];
    if (cfg.parEn) frame[parPos] = parBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldByte <= '0;
      shReg    <= '1;
      txLine   <= 1'b1;
    end else begin
      if (ctl.latchByte) heldByte <= inData;
      if (ctl.loadFrame) begin
        txLine <= frame[0];
        shReg  <= {1'b1, frame[FRAME_W-1:1]};
      end else if (ctl.shift) begin
        txLine <= shReg[0];
        shReg  <= {1'b1, shReg[FRAME_W-1:1]};
      end else if (ctl.setLevel) begin
        txLine <= ctl.level;
      end
    end
  end
endmodule

// File: rtl/uart_tx_ctrl.sv
module uart_tx_ctrl
  import uart_tx_pkg::*;
#(
  parameter int BRK_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitTick,
  input  txCfg_t           cfgIn,
  input  logic             brkReq,
  input  logic [BRK_W-1:0] brkCount,
  input  logic             restart,
  input  logic             inValid,
  input  logic             inPre,
  output logic             inReady,
  output txCfg_t           cfgUse,
  output dpCtl_t           ctl,
  output logic             busy
);
  typedef enum logic [2:0] {S_IDLE, S_BRK, S_POST, S_PRE, S_DATA} txState_t;

  txState_t         state, stateN;
  logic [LEN_W-1:0] bitCnt, bitCntN, len;
  logic [BRK_W-1:0] chrCnt, chrCntN, brkEnd, brkEndN;
  txCfg_t           cfgQ, cfgQN;
  logic             brkPend, brkPendN, rstPend, rstPendN;
  logic             charEnd, decide;

  always_comb begin
    cfgUse  = (state == S_IDLE) ? cfgIn : cfgQ;
    len     = frameLen(cfgQ);
    charEnd = (bitCnt == len - 1'b1);
    decide  = bitTick && ((state == S_IDLE) ||
              (charEnd && (state == S_DATA || state == S_POST)));
    inReady = decide && !brkPend;

    stateN  = state;
    bitCntN = bitCnt;
    chrCntN = chrCnt;
    brkEndN = brkEnd;
    cfgQN   = cfgQ;
    ctl     = '0;

    if (bitTick) begin
      case (state)
        S_BRK: begin
          if (rstPend || (charEnd && chrCnt == brkEnd)) begin
            stateN       = S_POST;
            bitCntN      = '0;
            ctl.setLevel = 1'b1;
            ctl.level    = 1'b1;
          end else if (charEnd) begin
            bitCntN = '0;
            chrCntN = chrCnt + 1'b1;
          end else begin
            bitCntN = bitCnt + 1'b1;
          end
        end
        S_PRE: begin
          if (charEnd) begin
            stateN        = S_DATA;
            bitCntN       = '0;
            ctl.loadFrame = 1'b1;
          end else begin
            bitCntN = bitCnt + 1'b1;
          end
        end
        S_DATA: begin
          if (!charEnd) begin
            bitCntN   = bitCnt + 1'b1;
            ctl.shift = 1'b1;
          end
        end
        S_POST: begin
          if (!charEnd) bitCntN = bitCnt + 1'b1;
        end
        default: ;
      endcase
    end

    if (decide) begin
      bitCntN = '0;
      if (state == S_IDLE) cfgQN = cfgIn;
      if (brkPend) begin
        stateN       = S_BRK;
        chrCntN      = '0;
        brkEndN      = (brkCount == '0) ? '0 : brkCount - 1'b1;
        ctl.setLevel = 1'b1;
        ctl.level    = 1'b0;
      end else if (inValid) begin
        ctl.latchByte = 1'b1;
        if (inPre) begin
          stateN       = S_PRE;
          ctl.setLevel = 1'b1;
          ctl.level    = 1'b1;
        end else begin
          stateN        = S_DATA;
          ctl.useIn     = 1'b1;
          ctl.loadFrame = 1'b1;
        end
      end else begin
        stateN       = S_IDLE;
        ctl.setLevel = 1'b1;
        ctl.level    = 1'b1;
      end
    end

    if (decide && brkPend)                brkPendN = 1'b0;
    else if (brkReq && state != S_BRK)    brkPendN = 1'b1;
    else                                  brkPendN = brkPend;
    rstPendN = (stateN == S_BRK) && (rstPend || restart);
  end

  assign busy = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      bitCnt  <= '0;
      chrCnt  <= '0;
      brkEnd  <= '0;
      cfgQ    <= '0;
      brkPend <= 1'b0;
      rstPend <= 1'b0;
    end else begin
      state   <= stateN;
      bitCnt  <= bitCntN;
      chrCnt  <= chrCntN;
      brkEnd  <= brkEndN;
      cfgQ    <= cfgQN;
      brkPend <= brkPendN;
      rstPend <= rstPendN;
    end
  end
endmodule

// File: rtl/uart_tx_brk.sv
module uart_tx_brk
  import uart_tx_pkg::*;
#(
  parameter int BRK_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitTick,
  input  logic [1:0]       cfgDataSel,
  input  logic             cfgParEn,
  input  logic             cfgParOdd,
  input  logic             cfgTwoStop,
  input  logic             brkReq,
  input  logic [BRK_W-1:0] brkCount,
  input  logic             restart,
  input  logic             inValid,
  input  logic [7:0]       inData,
  input  logic             inPre,
  output logic             inReady,
  output logic             txLine,
  output logic             busy
);
  txCfg_t cfgIn, cfgUse;
  dpCtl_t ctl;

  assign cfgIn = '{dataSel: cfgDataSel, parEn: cfgParEn, parOdd: cfgParOdd, twoStop: cfgTwoStop};

  uart_tx_ctrl #(.BRK_W(BRK_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .cfgIn(cfgIn),
    .brkReq(brkReq), .brkCount(brkCount), .restart(restart),
    .inValid(inValid), .inPre(inPre), .inReady(inReady),
    .cfgUse(cfgUse), .ctl(ctl), .busy(busy)
  );

  uart_tx_dp u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cfg(cfgUse),
    .inData(inData), .txLine(txLine)
  );
endmodule

// File: rtl/uart_tx_chk.sv
module uart_tx_chk (
  input logic clk,
  input logic rstN,
  input logic bitTick,
  input logic inValid,
  input logic inPre,
  input logic inReady,
  input logic txLine,
  input logic busy
);
  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> txLine); // R10
  AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rstN)
    !bitTick |=> $stable(txLine)); // R2
  AST_READY_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> bitTick); // R5
  AST_START_BIT_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    (inReady && inValid && !inPre) |=> (!txLine && busy)); // R2
  AST_PREAMBLE_STARTS_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (inReady && inValid && inPre) |=> (txLine && busy)); // R6
endmodule

bind uart_tx_brk uart_tx_chk u_chk (
  .clk(clk), .rstN(rstN), .bitTick(bitTick), .inValid(inValid), .inPre(inPre),
  .inReady(inReady), .txLine(txLine), .busy(busy)
);

// File: tb/uart_tx_brk_tb.sv
`timescale 1ns/1ps
module uart_tx_brk_tb;
  localparam int BRK_W = 8;
  localparam int TICK_DIV = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitTick = 1'b0;
  logic [1:0] cfgDataSel = 2'd3;
  logic cfgParEn = 1'b0, cfgParOdd = 1'b0, cfgTwoStop = 1'b0;
  logic brkReq = 1'b0, restart = 1'b0;
  logic [BRK_W-1:0] brkCount = '0;
  logic inValid = 1'b0, inPre = 1'b0;
  logic [7:0] inData = '0;
  logic inReady, txLine, busy;

  always #2.5 clk = ~clk;

  uart_tx_brk #(.BRK_W(BRK_W)) u_dut (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .cfgDataSel(cfgDataSel),
    .cfgParEn(cfgParEn), .cfgParOdd(cfgParOdd), .cfgTwoStop(cfgTwoStop),
    .brkReq(brkReq), .brkCount(brkCount), .restart(restart),
    .inValid(inValid), .inData(inData), .inPre(inPre),
    .inReady(inReady), .txLine(txLine), .busy(busy)
  );

  int tests = 0, fails = 0;
  string curTag = "R2";

  // stimulus source
  int byteQ[$];
  bit preQ[$];
  bit reqBrk = 0, reqRst = 0, acceptFlag = 0;
  int tickCnt = 0;

  // reference model: bits still to be put on the line and their kinds
  // kinds: 0 idle, 1 break, 2 post-break idle, 3 preamble, 4 data
  bit lineQ[$];
  int kindQ[$];
  int curKind = 0;
  bit mBrkPend = 0, mRstPend = 0;
  bit expLine = 1, expBusy = 0, expReady = 0;
  int mSel = 0, mPe = 0, mPo = 0, mTs = 0, mLen = 10;

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic void pushBits(input bit v, input int n, input int kind);
    for (int i = 0; i < n; i++) begin lineQ.push_back(v); kindQ.push_back(kind); end
  endfunction

  function automatic void pushFrame(input int b);
    int d = 5 + mSel;
    int ones = 0;
    lineQ.push_back(1'b0); kindQ.push_back(4);
    for (int i = 0; i < d; i++) begin
      bit v = b[i];
      ones += int'(v);
      lineQ.push_back(v); kindQ.push_back(4);
    end
    if (mPe != 0) begin
      lineQ.push_back(((ones % 2) != 0) ^ (mPo != 0)); kindQ.push_back(4);
    end
    pushBits(1'b1, 1 + mTs, 4);
  endfunction

  // one model step for the coming clock edge, inputs already driven
  task automatic modelStep();
    bit decide = bitTick && (lineQ.size() == 0);
    int oldKind = curKind;
    expReady = decide && !mBrkPend;
    chk("R5", "inReady", inReady, expReady);
    if (bitTick) begin
      if (mRstPend && curKind == 1)
        while (kindQ.size() > 0 && kindQ[0] == 1) begin void'(lineQ.pop_front()); void'(kindQ.pop_front()); end
      if (lineQ.size() == 0) begin
        if (curKind == 0) begin
          mSel = cfgDataSel; mPe = cfgParEn; mPo = cfgParOdd; mTs = cfgTwoStop;
          mLen = 7 + mSel + mPe + mTs;
        end
        if (mBrkPend) begin
          pushBits(1'b0, mLen * ((brkCount == 0) ? 1 : int'(brkCount)), 1);
          pushBits(1'b1, mLen, 2);
        end else if (inValid) begin
          acceptFlag = 1;
          if (inPre) pushBits(1'b1, mLen, 3);
          pushFrame(int'(inData));
        end
      end
      if (lineQ.size() > 0) begin
        expLine = lineQ.pop_front();
        curKind = kindQ.pop_front();
        expBusy = 1;
      end else begin
        expLine = 1; curKind = 0; expBusy = 0;
      end
    end
    if (decide && mBrkPend) mBrkPend = 0;
    else if (brkReq && oldKind != 1) mBrkPend = 1;
    mRstPend = (curKind == 1) && (mRstPend || restart);
  endtask

  task automatic modelLoop();
    forever begin
      @(negedge clk);
      chk(curTag, "txLine", txLine, expLine);
      chk("R10", "busy", busy, expBusy);
      if (acceptFlag) begin
        void'(byteQ.pop_front()); void'(preQ.pop_front()); acceptFlag = 0;
      end
      bitTick = (tickCnt == 0);
      tickCnt = (tickCnt + 1) % TICK_DIV;
      brkReq = 0; restart = 0;
      if (reqBrk && !bitTick) begin brkReq = 1; reqBrk = 0; end
      if (reqRst && !bitTick) begin restart = 1; reqRst = 0; end
      inValid = (byteQ.size() > 0);
      inData  = inValid ? 8'(byteQ[0]) : 8'h00;
      inPre   = inValid ? preQ[0] : 1'b0;
      #1;
      modelStep();
    end
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic waitIdle();
    do step(); while (byteQ.size() != 0 || lineQ.size() != 0 || curKind != 0 ||
                      reqBrk || reqRst || mBrkPend || acceptFlag);
    repeat (6) step();
  endtask

  task automatic setCfg(input int sel, input bit pe, input bit po, input bit ts);
    cfgDataSel = 2'(sel); cfgParEn = pe; cfgParOdd = po; cfgTwoStop = ts;
  endtask

  task automatic queueByte(input int b, input bit p);
    byteQ.push_back(b); preQ.push_back(p);
  endtask

  task automatic waitKind(input int k);
    do step(); while (curKind != k);
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R1: reset state with no bit strobe
    repeat (4) begin
      @(negedge clk);
      chk("R1", "txLine", txLine, 1'b1);
      chk("R1", "busy", busy, 1'b0);
      chk("R1", "inReady", inReady, 1'b0);
    end
    @(posedge clk); #2 rstN = 1'b1;
    fork
      modelLoop();
    join_none

    // R2 R5: 8N1 back-to-back bytes, no gap
    curTag = "R2"; setCfg(3, 0, 0, 0);
    queueByte(8'hA5, 0); queueByte(8'h3C, 0); queueByte(8'hFF, 0);
    waitIdle();
    curTag = "R5"; queueByte(8'h00, 0); queueByte(8'h81, 0);
    waitIdle();

    // R3: 7 data bits, even parity; then odd parity with 5 bits and R4 two stops
    curTag = "R3"; setCfg(2, 1, 0, 0);
    queueByte(8'h55, 0); queueByte(8'h7F, 0); queueByte(8'h01, 0);
    waitIdle();
    curTag = "R4"; setCfg(0, 1, 1, 1);
    queueByte(8'h1F, 0); queueByte(8'h0A, 0);
    waitIdle();

    // R6: preamble of 10 ones in 8N1, then a plain byte
    curTag = "R6"; setCfg(3, 0, 0, 0);
    queueByte(8'h00, 1); queueByte(8'hC3, 0); queueByte(8'h96, 1);
    waitIdle();

    // R7 R8: break of 2 frames, byte waits for post-break idle
    curTag = "R7"; brkCount = 8'd2; reqBrk = 1; step();
    queueByte(8'h5A, 0);
    waitKind(1); waitKind(2);
    curTag = "R8";
    waitIdle();
    // R7: count 0 acts as one frame, with 7-bit parity frames
    curTag = "R7"; setCfg(2, 1, 1, 0); brkCount = 8'd0; reqBrk = 1;
    waitKind(1);
    reqBrk = 1; // R7: request during a break is ignored
    waitIdle();

    // R12: break requested mid-message wins over queued bytes
    curTag = "R12"; setCfg(3, 0, 0, 0); brkCount = 8'd1;
    queueByte(8'h11, 0); queueByte(8'h22, 0); queueByte(8'h33, 1);
    waitKind(4); repeat (5) step(); reqBrk = 1;
    waitIdle();

    // R9: restart cuts a 5-frame break short, then a restart while idle
    curTag = "R9"; brkCount = 8'd5; reqBrk = 1;
    queueByte(8'hE7, 0);
    waitKind(1); repeat (70) step(); reqRst = 1;
    waitIdle();
    reqRst = 1; repeat (30) step();
    chk("R9", "idle busy after stray restart", busy, 1'b0);
    waitIdle();

    // R11: format change during a message is not picked up until idle
    curTag = "R11"; setCfg(3, 0, 0, 0);
    queueByte(8'hF0, 0); queueByte(8'h0F, 0); queueByte(8'hAA, 1);
    waitKind(4); repeat (4) step();
    setCfg(0, 1, 1, 1);
    waitIdle();
    queueByte(8'h13, 0);
    waitIdle();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule